// File: doc/BRIEF.md
# Capture Trigger Sequencer

This block watches a parallel bundle of sampled logic channels and raises a one-cycle trigger pulse once a programmed chain of conditions has been met in order. A capture engine uses the pulse to decide where its acquisition window lands. Each link of the chain has one of four kinds:
- **Pattern match:** a masked comparison of the channels.
- **Edge count:** counts rising edges on one chosen channel.
- **Fixed wait:** a delay of a set number of sample clocks.
- **Bounded wait:** waits for a pattern, and sends the chain back to its first link if the pattern does not arrive in time.

Channel inputs are treated as asynchronous. They pass through a flop synchronizer and then a registered match pipeline. Because of this, the delay from a pattern at the pins to the trigger pulse is the same on every run.

Stages are written one at a time through a simple write port. A separate input selects the index of the final stage. An arm command starts the chain, and a clear command abandons it. While the chain runs, the block shows the current stage index and an armed flag. A sticky triggered flag shows that a capture point has been reached.

Top module: `capture_trigger_seq`

## Requirements
- R1: After reset, trig_out, armed and triggered are 0 and cur_stage is 0.
- R2: A pattern stage is satisfied in a sample where every channel with its mask bit at 1 equals the matching value bit. Channels with mask bit 0 have no effect.
- R3: With SYNC_DEPTH=2, a satisfying pattern on the final stage that is set up before clock edge e makes trig_out high right after edge e+3, which is SYNC_DEPTH+2 edges counting e.
- R4: Stages are taken in order from index 0 up to chain_last. cur_stage shows the index of the stage being evaluated. The trigger fires when stage chain_last is satisfied.
- R5: An edge-count stage advances on the N-th rising edge of the channel that its edge selector picks, where N is its count.
- R6: A fixed-wait stage with count D advances exactly D clocks after it was entered, with no regard to the inputs.
- R7: A bounded-wait stage advances when its pattern matches. If its count of D clocks runs out first, the chain goes back to stage 0 and stays armed.
- R8: trig_out is high for exactly one clock. On firing, armed drops, cur_stage returns to 0, and triggered is set. triggered stays set until the next arm.
- R9: arm sets armed, clears triggered and starts at stage 0. clear drops armed and returns to stage 0, and clear wins when both are high.
- R10: While armed is 0, no input pattern produces a trigger.
- R11: The stage kind code is 0 for pattern, 1 for edge count, 2 for fixed wait and 3 for bounded wait. A count of 0 acts as 1. A stage is written in the clock where cfg_we is high, at index cfg_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_in | input | CH_W | Asynchronous channel bundle |
| cfg_we | input | 1 | Write strobe for one stage entry |
| cfg_idx | input | log2(STAGES) | Stage index being written |
| cfg_kind | input | 2 | Stage kind code |
| cfg_count | input | CNT_W | Edge count or wait length |
| cfg_value | input | CH_W | Pattern value |
| cfg_mask | input | CH_W | Pattern mask, 1 = compared |
| cfg_edge_ch | input | log2(CH_W) | Channel whose rising edges are counted |
| chain_last | input | log2(STAGES) | Index of the final stage |
| arm | input | 1 | Start the chain at stage 0 |
| clear | input | 1 | Abandon the chain |
| trig_out | output | 1 | One-clock trigger pulse |
| armed | output | 1 | Chain is running |
| triggered | output | 1 | Sticky: trigger has fired since last arm |
| cur_stage | output | log2(STAGES) | Current stage index |

## Verification
A pattern applied at the pins reaches the stage logic after SYNC_DEPTH synchronizer flops plus one match register. That stage acts on the following edge, so a satisfying final pattern set up ahead of edge e is due as a trigger right after edge e+3. Each time the bench changes the channels, it computes that due cycle from its own free-running cycle counter and queues it. A monitor samples trig_out on the falling edge and pops each trigger against the queue, and an item that goes past its due cycle is reported as missed. Wait stages are timed the same way: the stage is entered four edges after its pattern was set up, and the bench predicts every stage change from that point, counting each D-cycle wait or timeout. cur_stage is then sampled one cycle before and one cycle after each predicted change.

// File: rtl/trgseq_pkg.sv
package trgseq_pkg;

   // Stage kind codes (bit values are visible at the configuration port)
   typedef enum logic [1:0] {
      K_PATTERN = 2'd0,
      K_EDGES   = 2'd1,
      K_DELAY   = 2'd2,
      K_TIMEOUT = 2'd3
   } stage_kind_e;

endpackage

// File: rtl/trgseq_sync.sv
module trgseq_sync #(
   parameter int W     = 8,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_flop
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign q = chain[DEPTH-1];
endmodule

// File: rtl/trgseq_cfg_bank.sv
module trgseq_cfg_bank
   import trgseq_pkg::*;
#(
   parameter int CH_W   = 8,
   parameter int STAGES = 4,
   parameter int CNT_W  = 16,
   localparam int IDX_W = $clog2(STAGES),
   localparam int SEL_W = $clog2(CH_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [1:0]        kind_in,
   input  logic [CNT_W-1:0]  count_in,
   input  logic [CH_W-1:0]   value_in,
   input  logic [CH_W-1:0]   mask_in,
   input  logic [SEL_W-1:0]  sel_in,
   output stage_kind_e       kind  [STAGES],
   output logic [CNT_W-1:0]  count [STAGES],
   output logic [CH_W-1:0]   value [STAGES],
   output logic [CH_W-1:0]   mask  [STAGES],
   output logic [SEL_W-1:0]  sel   [STAGES]
);
   for (genvar g = 0; g < STAGES; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            kind[g]  <= K_PATTERN;
            count[g] <= '0;
            value[g] <= '0;
            mask[g]  <= '0;
            sel[g]   <= '0;
         end else if (we && (idx == IDX_W'(g))) begin
            kind[g]  <= stage_kind_e'(kind_in);
            count[g] <= count_in;
            value[g] <= value_in;
            mask[g]  <= mask_in;
            sel[g]   <= sel_in;
         end
      end
   end
endmodule

// File: rtl/trgseq_match.sv
module trgseq_match #(
   parameter int CH_W   = 8,
   parameter int STAGES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CH_W-1:0]   sy,
   input  logic [CH_W-1:0]   value [STAGES],
   input  logic [CH_W-1:0]   mask  [STAGES],
   output logic [STAGES-1:0] match_q,
   output logic [CH_W-1:0]   rise_q
);
   logic [CH_W-1:0] sy_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sy_d   <= '0;
         rise_q <= '0;
      end else begin
         sy_d   <= sy;
         rise_q <= sy & ~sy_d;
      end
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_cmp
      always_ff @(posedge clk) begin
         if (!rst_n) match_q[g] <= 1'b0;
         else        match_q[g] <= (((sy ^ value[g]) & mask[g]) == '0);
      end
   end
endmodule

// File: rtl/trgseq_fsm.sv
module trgseq_fsm
   import trgseq_pkg::*;
#(
   parameter int CH_W   = 8,
   parameter int STAGES = 4,
   parameter int CNT_W  = 16,
   localparam int IDX_W = $clog2(STAGES),
   localparam int SEL_W = $clog2(CH_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              clear,
   input  logic [IDX_W-1:0]  last,
   input  stage_kind_e       kind  [STAGES],
   input  logic [CNT_W-1:0]  count [STAGES],
   input  logic [SEL_W-1:0]  sel   [STAGES],
   input  logic [STAGES-1:0] match_q,
   input  logic [CH_W-1:0]   rise_q,
   output logic              trig_out,
   output logic              armed,
   output logic              triggered,
   output logic [IDX_W-1:0]  stage
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   cnt_nxt, need;
   logic             adv, restart, bump;

   always_comb begin
      cnt_nxt = {1'b0, cnt} + 1'b1;
      need    = (count[stage] == '0) ? (CNT_W+1)'(1) : {1'b0, count[stage]};
      adv     = 1'b0;
      restart = 1'b0;
      bump    = 1'b0;
      unique case (kind[stage])
         K_PATTERN: adv = match_q[stage];
         K_EDGES: begin
            if (rise_q[sel[stage]]) begin
               if (cnt_nxt >= need) adv  = 1'b1;
               else                 bump = 1'b1;
            end
         end
         K_DELAY: begin
            if (cnt_nxt >= need) adv  = 1'b1;
            else                 bump = 1'b1;
         end
         K_TIMEOUT: begin
            if (match_q[stage])       adv     = 1'b1;
            else if (cnt_nxt >= need) restart = 1'b1;
            else                      bump    = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trig_out  <= 1'b0;
         armed     <= 1'b0;
         triggered <= 1'b0;
         stage     <= '0;
         cnt       <= '0;
      end else begin
         trig_out <= 1'b0;
         if (clear) begin
            armed <= 1'b0;
            stage <= '0;
            cnt   <= '0;
         end else if (arm) begin
            armed     <= 1'b1;
            triggered <= 1'b0;
            stage     <= '0;
            cnt       <= '0;
         end else if (armed) begin
            if (adv) begin
               cnt <= '0;
               if (stage == last) begin
                  trig_out  <= 1'b1;
                  triggered <= 1'b1;
                  armed     <= 1'b0;
                  stage     <= '0;
               end else begin
                  stage <= stage + 1'b1;
               end
            end else if (restart) begin
               stage <= '0;
               cnt   <= '0;
            end else if (bump) begin
               cnt <= cnt_nxt[CNT_W-1:0];
            end
         end
      end
   end
endmodule

// File: rtl/capture_trigger_seq.sv
module capture_trigger_seq
   import trgseq_pkg::*;
#(
   parameter int CH_W       = 8,
   parameter int STAGES     = 4,
   parameter int CNT_W      = 16,
   parameter int SYNC_DEPTH = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [CH_W-1:0]           samp_in,
   input  logic                      cfg_we,
   input  logic [$clog2(STAGES)-1:0] cfg_idx,
   input  logic [1:0]                cfg_kind,
   input  logic [CNT_W-1:0]          cfg_count,
   input  logic [CH_W-1:0]           cfg_value,
   input  logic [CH_W-1:0]           cfg_mask,
   input  logic [$clog2(CH_W)-1:0]   cfg_edge_ch,
   input  logic [$clog2(STAGES)-1:0] chain_last,
   input  logic                      arm,
   input  logic                      clear,
   output logic                      trig_out,
   output logic                      armed,
   output logic                      triggered,
   output logic [$clog2(STAGES)-1:0] cur_stage
);
   localparam int SEL_W = $clog2(CH_W);

   if (SYNC_DEPTH < 2 || SYNC_DEPTH > 3) begin : g_bad_sync
      $error("SYNC_DEPTH must be 2 or 3");
   end
   if (STAGES < 2) begin : g_bad_stages
      $error("STAGES must be at least 2");
   end
   if (CH_W < 2) begin : g_bad_width
      $error("CH_W must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   logic [CH_W-1:0]   sy;
   stage_kind_e       kind  [STAGES];
   logic [CNT_W-1:0]  count [STAGES];
   logic [CH_W-1:0]   value [STAGES];
   logic [CH_W-1:0]   mask  [STAGES];
   logic [SEL_W-1:0]  sel   [STAGES];
   logic [STAGES-1:0] match_q;
   logic [CH_W-1:0]   rise_q;

   trgseq_sync #(.W(CH_W), .DEPTH(SYNC_DEPTH)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(samp_in), .q(sy)
   );

   trgseq_cfg_bank #(.CH_W(CH_W), .STAGES(STAGES), .CNT_W(CNT_W)) cfg_i (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx),
      .kind_in(cfg_kind), .count_in(cfg_count), .value_in(cfg_value),
      .mask_in(cfg_mask), .sel_in(cfg_edge_ch),
      .kind(kind), .count(count), .value(value), .mask(mask), .sel(sel)
   );

   trgseq_match #(.CH_W(CH_W), .STAGES(STAGES)) match_i (
      .clk(clk), .rst_n(rst_n), .sy(sy), .value(value), .mask(mask),
      .match_q(match_q), .rise_q(rise_q)
   );

   trgseq_fsm #(.CH_W(CH_W), .STAGES(STAGES), .CNT_W(CNT_W)) fsm_i (
      .clk(clk), .rst_n(rst_n), .arm(arm), .clear(clear), .last(chain_last),
      .kind(kind), .count(count), .sel(sel), .match_q(match_q), .rise_q(rise_q),
      .trig_out(trig_out), .armed(armed), .triggered(triggered), .stage(cur_stage)
   );
endmodule

// File: rtl/capture_trigger_seq_chk.sv
module capture_trigger_seq_chk #(
   parameter int IDX_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arm,
   input logic             clear,
   input logic [IDX_W-1:0] chain_last,
   input logic             trig_out,
   input logic             armed,
   input logic             triggered,
   input logic [IDX_W-1:0] cur_stage
);
   assert_trig_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |=> !trig_out);

   assert_fire_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |-> (triggered && !armed && cur_stage == '0));

   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (triggered && !arm) |=> triggered);

   assert_needs_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |-> $past(armed));

   assert_arm_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && !clear) |=> (armed && !triggered && cur_stage == '0));

   assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (!armed && cur_stage == '0));

   assert_idle_stage_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> cur_stage == '0);

   assert_stage_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> cur_stage <= chain_last);
endmodule

bind capture_trigger_seq capture_trigger_seq_chk #(.IDX_W($clog2(STAGES))) chk_i (
   .clk(clk), .rst_n(rst_n), .arm(arm), .clear(clear), .chain_last(chain_last),
   .trig_out(trig_out), .armed(armed), .triggered(triggered), .cur_stage(cur_stage)
);

// File: tb/capture_trigger_seq_tb_top.sv
module capture_trigger_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CH_W = 8;
   localparam int STAGES = 4;
   localparam int CNT_W = 16;
   localparam int LAT = 4;   // SYNC_DEPTH(2) + 2

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CH_W-1:0]  samp_in = '0;
   logic             cfg_we = 1'b0;
   logic [1:0]       cfg_idx = '0;
   logic [1:0]       cfg_kind = '0;
   logic [CNT_W-1:0] cfg_count = '0;
   logic [CH_W-1:0]  cfg_value = '0;
   logic [CH_W-1:0]  cfg_mask = '0;
   logic [2:0]       cfg_edge_ch = '0;
   logic [1:0]       chain_last = '0;
   logic             arm = 1'b0;
   logic             clear = 1'b0;
   logic             trig_out, armed, triggered;
   logic [1:0]       cur_stage;

   capture_trigger_seq #(.CH_W(CH_W), .STAGES(STAGES), .CNT_W(CNT_W), .SYNC_DEPTH(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .samp_in(samp_in), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_kind(cfg_kind), .cfg_count(cfg_count), .cfg_value(cfg_value),
      .cfg_mask(cfg_mask), .cfg_edge_ch(cfg_edge_ch), .chain_last(chain_last),
      .arm(arm), .clear(clear), .trig_out(trig_out), .armed(armed),
      .triggered(triggered), .cur_stage(cur_stage)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int    n_cmp = 0;
   int    n_bad = 0;
   int    exp_q[$];
   string req_q[$];
   bit    done = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // scoreboard monitor: triggers are popped against due cycles
   always @(negedge clk) begin
      if (rst_n && trig_out) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R10", "unexpected trigger at cycle", cyc, -1);
         end else begin
            int    e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(e == cyc, r, "trigger cycle", cyc, e);
         end
      end
      if (exp_q.size() > 0 && exp_q[0] < cyc) begin
         int    e;
         string r;
         e = exp_q.pop_front();
         r = req_q.pop_front();
         check(1'b0, r, "missed trigger due at", cyc, e);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_trig(input int due, input string req);
      exp_q.push_back(due);
      req_q.push_back(req);
   endtask

   // R11: kind code 0 pattern, 1 edges, 2 fixed wait, 3 bounded wait
   task automatic write_stage(input int idx, input int kind, input int count,
                              input logic [CH_W-1:0] val, input logic [CH_W-1:0] msk,
                              input int sel);
      cfg_idx     = 2'(idx);
      cfg_kind    = 2'(kind);
      cfg_count   = CNT_W'(count);
      cfg_value   = val;
      cfg_mask    = msk;
      cfg_edge_ch = 3'(sel);
      cfg_we      = 1'b1;
      tick(1);
      cfg_we      = 1'b0;
   endtask

   task automatic do_arm();
      arm = 1'b1;
      tick(1);
      arm = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
         report();
      end
   end

   initial begin
      int c;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      check(trig_out == 1'b0, "R1", "trig_out after reset", trig_out, 0);
      check(armed == 1'b0, "R1", "armed after reset", armed, 0);
      check(triggered == 1'b0, "R1", "triggered after reset", triggered, 0);
      check(cur_stage == 2'd0, "R1", "stage after reset", cur_stage, 0);

      // single pattern stage: ch0=1 and ch7=1 compared, others masked
      write_stage(0, 0, 0, 8'h81, 8'h81, 0);
      chain_last = 2'd0;
      do_arm();
      tick(3);
      check(armed == 1'b1, "R9", "armed after arm", armed, 1);
      samp_in = 8'h7E;   // masked channels toggled, compared ones at 0
      tick(4);
      samp_in = 8'h01;   // ch7 still mismatched
      tick(8);
      check(armed == 1'b1, "R2", "still armed with partial match", armed, 1);
      samp_in = 8'hFF;
      c = cyc;
      expect_trig(c + LAT, "R3");
      tick(6);
      check(triggered == 1'b1, "R8", "triggered sticky after fire", triggered, 1);
      check(armed == 1'b0, "R8", "armed drops on fire", armed, 0);
      // R10: pattern kept while disarmed gives nothing
      samp_in = 8'h81;
      tick(8);
      check(triggered == 1'b1, "R8", "triggered kept while idle", triggered, 1);
      samp_in = 8'h00;
      tick(5);
      do_arm();
      check(triggered == 1'b0, "R9", "arm clears triggered", triggered, 0);
      // masked-channel garbage plus compared bits -> fire (R2)
      samp_in = 8'h93;
      c = cyc;
      expect_trig(c + LAT, "R2");
      tick(6);
      samp_in = 8'h00;
      tick(5);

      // three-stage chain: ch0=1,ch1=0 ; 5 rising edges on ch1 ; ch0=0,ch2=0
      write_stage(0, 0, 0, 8'h01, 8'h03, 0);
      write_stage(1, 1, 5, 8'h00, 8'h00, 1);
      write_stage(2, 0, 0, 8'h00, 8'h05, 0);
      chain_last = 2'd2;
      samp_in = 8'h04;
      tick(5);
      do_arm();
      tick(3);
      samp_in = 8'h05;
      tick(6);
      check(cur_stage == 2'd1, "R4", "stage after first link", cur_stage, 1);
      for (int i = 0; i < 4; i++) begin
         samp_in = 8'h07; tick(2);
         samp_in = 8'h05; tick(2);
      end
      tick(4);
      check(cur_stage == 2'd1, "R5", "stage after 4 edges", cur_stage, 1);
      samp_in = 8'h07; tick(2);
      samp_in = 8'h05; tick(6);
      check(cur_stage == 2'd2, "R5", "stage after 5th edge", cur_stage, 2);
      samp_in = 8'h00;
      c = cyc;
      expect_trig(c + LAT, "R4");
      tick(6);
      check(cur_stage == 2'd0, "R8", "stage back to 0 after fire", cur_stage, 0);

      // fixed wait of 10 clocks between two patterns
      write_stage(0, 0, 0, 8'h08, 8'h08, 0);
      write_stage(1, 2, 10, 8'h00, 8'h00, 0);
      write_stage(2, 0, 0, 8'h10, 8'h10, 0);
      samp_in = 8'h00;
      tick(5);
      do_arm();
      tick(3);
      samp_in = 8'h18;
      c = cyc;
      expect_trig(c + 5 + 10, "R6");
      tick(13);
      check(cur_stage == 2'd1, "R6", "stage one clock before wait ends", cur_stage, 1);
      tick(1);
      check(cur_stage == 2'd2, "R6", "stage right after wait", cur_stage, 2);
      tick(5);
      samp_in = 8'h00;
      tick(5);

      // bounded wait of 6 clocks for ch6
      write_stage(0, 0, 0, 8'h20, 8'h20, 0);
      write_stage(1, 3, 6, 8'h40, 8'h40, 0);
      chain_last = 2'd1;
      do_arm();
      tick(3);
      samp_in = 8'h20;
      c = cyc;
      tick(1);
      samp_in = 8'h00;
      tick(8);   // now at c+9
      check(cur_stage == 2'd1, "R7", "stage before timeout", cur_stage, 1);
      tick(2);   // c+11
      check(cur_stage == 2'd0, "R7", "stage after timeout", cur_stage, 0);
      check(armed == 1'b1, "R7", "still armed after timeout", armed, 1);
      samp_in = 8'h20;
      c = cyc;
      tick(1);
      samp_in = 8'h00;
      tick(1);
      samp_in = 8'h40;
      expect_trig(c + 6, "R7");
      tick(6);
      samp_in = 8'h00;
      tick(5);

      // clear mid-chain, then no trigger (R9, R10)
      do_arm();
      tick(3);
      samp_in = 8'h20;
      tick(1);
      samp_in = 8'h00;
      tick(5);
      clear = 1'b1;
      tick(1);
      clear = 1'b0;
      check(armed == 1'b0, "R9", "armed after clear", armed, 0);
      check(cur_stage == 2'd0, "R9", "stage after clear", cur_stage, 0);
      samp_in = 8'h40;
      tick(8);
      samp_in = 8'h00;
      arm = 1'b1;
      clear = 1'b1;
      tick(1);
      arm = 1'b0;
      clear = 1'b0;
      check(armed == 1'b0, "R9", "clear wins over arm", armed, 0);

      tick(10);
      check(exp_q.size() == 0, "R3", "pending expected triggers", exp_q.size(), 0);
      done = 1'b1;
      report();
   end
endmodule